// File: doc/BRIEF.md
# Timebase synchronization controller

This block holds a 64-bit timebase facility control and status word and the synchronization state machine that lives inside it. Software sets command bits through a register-write port and checks progress through a register-read port. The machine does not run on its own clock. It moves one step each time software reads the word. Short countdowns make software poll a few times before each transition takes effect.

During synchronization the block works with an external time-of-day distributor. It raises `tod_ready` once it is waiting for a time value. It then watches `tod_sent` to learn that the value has been delivered. A latched flag holds that notice until the machine reaches the running state. The word also keeps the current state, the state before it, a valid flag and a sync-occurred flag. Illegal command sequences drive the machine into a sticky error state. Only a clear-errors write takes it out again.

Bits are numbered from the most significant end. Bit n of the word is vector index 63-n.

Top module: `tbsync_ctrl`

## Requirements
- R1: A synchronous active-high `rst` zeroes the word, both countdowns, `tod_ready`, the latched TOD-sent flag and `rd_data`. The first read after reset returns exactly the mode bit (bit 14).
- R2: A write with the mode bit set copies bits 0 to 24 of `wr_data` into the word. Bit 14 is mode, bit 16 is load-modulo, bit 18 is move-TOD and bit 24 is clear-errors. Bits 25 to 63 are status and are never copied from `wr_data`.
- R3: On every state change the previous-state field (bits 32 to 35) takes the old current-state field (bits 28 to 31) before the new state is written. The state codes are 0 reset, 1 send-mod, 2 not-set, 6 sync-wait, 7 get-TOD, 8 running and 9 error.
- R4: On each state change the valid flag (bit 40) becomes 1 if the new state is running and 0 for any other state.
- R5: A write with mode set clears sync-occurred (bit 42) and loads a one-step pulse countdown. The first enabled poll after that write leaves the flag clear, and the second poll sets it.
- R6: A write with mode set that has both load-modulo and move-TOD set moves the state to error and drops `tod_ready`.
- R7: While the state is error, polls change nothing. A write that has mode set but carries neither clear-errors nor the illegal pair also leaves the word unchanged.
- R8: A write with mode and clear-errors set (and not the illegal pair) enters the reset state. It clears clear-errors, load-modulo and move-TOD, and drops both `tod_ready` and the latched TOD-sent flag.
- R9: A load-modulo write loads a 3-step state countdown. The fourth poll clears load-modulo. From get-TOD that poll enters error. From any other state it passes through send-mod to not-set, so the previous-state field reads 1.
- R10: A move-TOD write while the state is not-set enters sync-wait, raises `tod_ready` and loads the 3-step countdown. The same write in any other state enters error and drops `tod_ready`.
- R11: While move-TOD is pending and the countdown is zero, a poll behaves by state. In sync-wait it enters get-TOD and reloads the countdown with 3. In get-TOD with TOD-sent latched it enters running, clears move-TOD and drops both handshake flags. In get-TOD without TOD-sent it does nothing. In any other state it enters error and drops `tod_ready`.
- R12: Polls do nothing while the stored mode bit is 0. Every read returns the mode bit as 1. A write with the mode bit 0 zeroes both state fields and changes nothing else.
- R13: A read presents the word after its poll step on `rd_data` one cycle later. When `wr_en` and `rd_en` are both high, only the write takes effect and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Value written to the word (control bits used) |
| rd_en | input | 1 | Register read strobe; advances the machine one step |
| rd_data | output | 64 | Word after the poll step, with the mode bit forced to 1 |
| tod_sent | input | 1 | Level from the time-of-day distributor: value delivered |
| tod_ready | output | 1 | Ready to receive a time-of-day value |

## Verification
The bound checker watches several rules on every cycle:
- each state change records the old state as the previous state;
- the valid flag follows the new state;
- a write clears sync-occurred;
- the word stays frozen while in error unless a clearing or illegal write arrives;
- `tod_ready` rises only on entry to sync-wait;
- reads always show the mode bit;
- polls freeze the word while mode is clear.

The countdown lengths, the send-mod pass-through and the full load and move sequences can only be shown by the bench's ordered scenarios. The same holds for the dependence on a latched TOD-sent notice, write priority over a same-cycle read, and leaving error through clear-errors.

// File: rtl/tbsync_pkg.sv
package tbsync_pkg;

  localparam int REG_W = 64;

  // Bit n counted from the most significant end sits at index REG_W-1-n.
  function automatic int msb_bit(input int n);
    return REG_W - 1 - n;
  endfunction

  localparam int B_MODE  = msb_bit(14);
  localparam int B_LOAD  = msb_bit(16);
  localparam int B_MOVE  = msb_bit(18);
  localparam int B_CLR   = msb_bit(24);
  localparam int CTL_LO  = msb_bit(24);
  localparam int CUR_HI  = msb_bit(28);
  localparam int CUR_LO  = msb_bit(31);
  localparam int PRV_HI  = msb_bit(32);
  localparam int PRV_LO  = msb_bit(35);
  localparam int B_VALID = msb_bit(40);
  localparam int B_SYNC  = msb_bit(42);

  typedef enum logic [3:0] {
    ST_RESET     = 4'h0,
    ST_SEND_MOD  = 4'h1,
    ST_NOT_SET   = 4'h2,
    ST_SYNC_WAIT = 4'h6,
    ST_GET_TOD   = 4'h7,
    ST_RUNNING   = 4'h8,
    ST_ERROR     = 4'h9
  } tb_state_e;

  // Shift current state into history, install new state, update valid.
  function automatic logic [REG_W-1:0] enter_state(input logic [REG_W-1:0] r,
                                                   input tb_state_e s);
    logic [REG_W-1:0] o;
    o = r;
    o[PRV_HI:PRV_LO] = r[CUR_HI:CUR_LO];
    o[CUR_HI:CUR_LO] = s;
    o[B_VALID]       = (s == ST_RUNNING);
    return o;
  endfunction

endpackage

// File: rtl/tbsync_countdown.sv
module tbsync_countdown #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/tbsync_next.sv
module tbsync_next
  import tbsync_pkg::*;
(
  input  logic [REG_W-1:0] word_q,
  input  logic             ready_q,
  input  logic             tod_seen_q,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             poll,
  input  logic             st_zero,
  input  logic             sy_zero,
  output logic [REG_W-1:0] word_n,
  output logic             ready_n,
  output logic             tod_clr,
  output logic             st_load,
  output logic             sy_load,
  output logic             st_dec,
  output logic             sy_dec
);

  tb_state_e st;
  logic [REG_W-1:0] merged;
  logic unused_status;

  assign st = tb_state_e'(word_q[CUR_HI:CUR_LO]);
  assign unused_status = ^wr_data[CTL_LO-1:0];

  // Written control bits replace stored ones; a write always clears sync.
  always_comb begin
    merged = word_q;
    merged[REG_W-1:CTL_LO] = wr_data[REG_W-1:CTL_LO];
    merged[B_SYNC] = 1'b0;
  end

  always_comb begin
    word_n  = word_q;
    ready_n = ready_q;
    tod_clr = 1'b0;
    st_load = 1'b0;
    sy_load = 1'b0;
    st_dec  = 1'b0;
    sy_dec  = 1'b0;

    if (wr_en) begin
      if (!wr_data[B_MODE]) begin
        word_n[CUR_HI:CUR_LO] = 4'h0;
        word_n[PRV_HI:PRV_LO] = 4'h0;
      end else begin
        sy_load = 1'b1;
        if (wr_data[B_LOAD] && wr_data[B_MOVE]) begin
          word_n  = enter_state(merged, ST_ERROR);
          ready_n = 1'b0;
        end else if (wr_data[B_CLR]) begin
          word_n = enter_state(merged, ST_RESET);
          word_n[B_CLR]  = 1'b0;
          word_n[B_LOAD] = 1'b0;
          word_n[B_MOVE] = 1'b0;
          ready_n = 1'b0;
          tod_clr = 1'b1;
        end else if (st == ST_ERROR) begin
          word_n = word_q;
        end else begin
          word_n = merged;
          if (wr_data[B_LOAD]) begin
            st_load = 1'b1;
          end else if (wr_data[B_MOVE]) begin
            if (st == ST_NOT_SET) begin
              word_n  = enter_state(merged, ST_SYNC_WAIT);
              ready_n = 1'b1;
              st_load = 1'b1;
            end else begin
              word_n  = enter_state(merged, ST_ERROR);
              ready_n = 1'b0;
            end
          end
        end
      end
    end else if (poll && word_q[B_MODE] && (st != ST_ERROR)) begin
      if (!sy_zero) sy_dec = 1'b1;
      else          word_n[B_SYNC] = 1'b1;

      if (!st_zero) begin
        st_dec = 1'b1;
      end else if (word_q[B_LOAD]) begin
        word_n[B_LOAD] = 1'b0;
        if (st == ST_GET_TOD) begin
          word_n = enter_state(word_n, ST_ERROR);
        end else begin
          word_n = enter_state(enter_state(word_n, ST_SEND_MOD), ST_NOT_SET);
        end
      end else if (word_q[B_MOVE]) begin
        if (st == ST_SYNC_WAIT) begin
          word_n  = enter_state(word_n, ST_GET_TOD);
          st_load = 1'b1;
        end else if (st == ST_GET_TOD) begin
          if (tod_seen_q) begin
            word_n = enter_state(word_n, ST_RUNNING);
            word_n[B_MOVE] = 1'b0;
            ready_n = 1'b0;
            tod_clr = 1'b1;
          end
        end else begin
          word_n  = enter_state(word_n, ST_ERROR);
          ready_n = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/tbsync_ctrl.sv
module tbsync_ctrl
  import tbsync_pkg::*;
#(
  parameter int STATE_DELAY = 3,
  parameter int PULSE_DELAY = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             tod_sent,
  output logic             tod_ready
);

  localparam int MAX_DELAY = (STATE_DELAY > PULSE_DELAY) ? STATE_DELAY : PULSE_DELAY;
  localparam int CNT_W     = $clog2(MAX_DELAY + 1);
  localparam int N_CNT     = 2;

  logic [REG_W-1:0] word_q, word_n;
  logic             ready_q, ready_n;
  logic             tod_seen_q;
  logic             tod_clr;
  logic             poll;
  logic             st_load, sy_load, st_dec, sy_dec;

  logic             cnt_load [N_CNT];
  logic             cnt_dec  [N_CNT];
  logic             cnt_zero [N_CNT];
  logic [CNT_W-1:0] cnt_val  [N_CNT];

  assign poll = rd_en && !wr_en;

  // Index 0: state countdown, index 1: sync pulse countdown.
  assign cnt_load[0] = st_load;
  assign cnt_dec[0]  = st_dec;
  assign cnt_val[0]  = CNT_W'(STATE_DELAY);
  assign cnt_load[1] = sy_load;
  assign cnt_dec[1]  = sy_dec;
  assign cnt_val[1]  = CNT_W'(PULSE_DELAY);

  for (genvar i = 0; i < N_CNT; i++) begin : g_cnt
    tbsync_countdown #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (cnt_load[i]),
      .load_val (cnt_val[i]),
      .dec      (cnt_dec[i]),
      .zero     (cnt_zero[i])
    );
  end

  tbsync_next u_next (
    .word_q     (word_q),
    .ready_q    (ready_q),
    .tod_seen_q (tod_seen_q),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .poll       (poll),
    .st_zero    (cnt_zero[0]),
    .sy_zero    (cnt_zero[1]),
    .word_n     (word_n),
    .ready_n    (ready_n),
    .tod_clr    (tod_clr),
    .st_load    (st_load),
    .sy_load    (sy_load),
    .st_dec     (st_dec),
    .sy_dec     (sy_dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q     <= '0;
      ready_q    <= 1'b0;
      tod_seen_q <= 1'b0;
      rd_data    <= '0;
    end else begin
      word_q     <= word_n;
      ready_q    <= ready_n;
      tod_seen_q <= tod_clr ? 1'b0 : (tod_seen_q | tod_sent);
      if (poll) begin
        rd_data <= word_n | (REG_W'(1) << B_MODE);
      end
    end
  end

  assign tod_ready = ready_q;

endmodule

// File: rtl/tbsync_ctrl_chk.sv
module tbsync_ctrl_chk
  import tbsync_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic             rd_en,
  input logic [REG_W-1:0] rd_data,
  input logic             tod_ready,
  input logic [REG_W-1:0] word_q
);

  logic       past_ok;
  logic [3:0] cur, prv;
  logic       mode_clr_wr, frees_error;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign cur         = word_q[CUR_HI:CUR_LO];
  assign prv         = word_q[PRV_HI:PRV_LO];
  assign mode_clr_wr = wr_en && !wr_data[B_MODE];
  assign frees_error = wr_en && (!wr_data[B_MODE] || wr_data[B_CLR] ||
                                 (wr_data[B_LOAD] && wr_data[B_MOVE]));

  // R3: history follows every state change (not-set entry handled by R9 check)
  p_prev_tracks_r3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cur != $past(cur) && !$past(mode_clr_wr) && cur != 4'h2)
      |-> prv == $past(cur));

  // R9: entering not-set through load-modulo shows send-mod as previous
  p_sendmod_hist_r9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cur == 4'h2 && $past(cur) != 4'h2 && !$past(mode_clr_wr))
      |-> prv == 4'h1);

  // R4: valid follows the newly entered state
  p_valid_state_r4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && cur != $past(cur) && !$past(mode_clr_wr))
      |-> word_q[B_VALID] == (cur == 4'h8));

  // R5: an accepted write leaves sync-occurred clear
  p_sync_cleared_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[B_MODE] && (cur != 4'h9 || frees_error))
      |=> !word_q[B_SYNC]);

  // R7: error state freezes the word
  p_error_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    (cur == 4'h9 && !frees_error) |=> $stable(word_q));

  // R10: handshake request only appears on entry to sync-wait
  p_ready_rise_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(tod_ready) |-> cur == 4'h6);

  // R12: every read shows the mode bit
  p_mode_read_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en) |=> rd_data[B_MODE]);

  // R12: polls with mode clear leave the word alone
  p_poll_off_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && !word_q[B_MODE]) |=> $stable(word_q));

endmodule

bind tbsync_ctrl tbsync_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .tod_ready (tod_ready),
  .word_q    (word_q)
);

// File: tb/tb_tbsync_ctrl.sv
`timescale 1ns/1ps
module tb_tbsync_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [63:0] rd_data;
  logic        tod_sent = 1'b0;
  logic        tod_ready;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tbsync_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tod_sent(tod_sent), .tod_ready(tod_ready)
  );

  // Field positions: bit n (MSB-first) is index 63-n.
  localparam logic [63:0] M  = 64'h1 << 49;  // mode, bit 14
  localparam logic [63:0] LD = 64'h1 << 47;  // load-modulo, bit 16
  localparam logic [63:0] MV = 64'h1 << 45;  // move-TOD, bit 18
  localparam logic [63:0] CL = 64'h1 << 39;  // clear-errors, bit 24

  function automatic logic [63:0] ex(input logic [63:0] ctl, input logic [3:0] c,
                                     input logic [3:0] p, input logic v, input logic s);
    return ctl | (64'(c) << 32) | (64'(p) << 28) | (64'(v) << 23) | (64'(s) << 21);
  endfunction

  localparam logic [1:0] OP_R = 2'd0, OP_W = 2'd1, OP_T = 2'd2;
  localparam int NV = 28;
  // {op, write value, expected read, expected tod_ready}
  localparam logic [130:0] VEC [NV] = '{
    {OP_R, 64'd0,        ex(M,0,0,0,0),        1'b0},  // 0  R12 poll off, R1
    {OP_W, CL|M,         64'd0,                1'b0},  // 1  R8
    {OP_R, 64'd0,        ex(M,0,0,0,0),        1'b0},  // 2  R5 first poll
    {OP_R, 64'd0,        ex(M,0,0,0,1),        1'b0},  // 3  R5 second poll
    {OP_W, LD|M,         64'd0,                1'b0},  // 4
    {OP_R, 64'd0,        ex(M|LD,0,0,0,0),     1'b0},  // 5  R2 control latched
    {OP_R, 64'd0,        ex(M|LD,0,0,0,1),     1'b0},  // 6
    {OP_R, 64'd0,        ex(M|LD,0,0,0,1),     1'b0},  // 7
    {OP_R, 64'd0,        ex(M,2,1,0,1),        1'b0},  // 8  R9 send-mod history
    {OP_W, MV|M,         64'd0,                1'b1},  // 9  R10
    {OP_R, 64'd0,        ex(M|MV,6,2,0,0),     1'b1},  // 10 R10 R3
    {OP_R, 64'd0,        ex(M|MV,6,2,0,1),     1'b1},  // 11
    {OP_R, 64'd0,        ex(M|MV,6,2,0,1),     1'b1},  // 12
    {OP_R, 64'd0,        ex(M|MV,7,6,0,1),     1'b1},  // 13 R11 get-TOD
    {OP_R, 64'd0,        ex(M|MV,7,6,0,1),     1'b1},  // 14
    {OP_R, 64'd0,        ex(M|MV,7,6,0,1),     1'b1},  // 15
    {OP_R, 64'd0,        ex(M|MV,7,6,0,1),     1'b1},  // 16
    {OP_R, 64'd0,        ex(M|MV,7,6,0,1),     1'b1},  // 17 R11 no TOD yet
    {OP_T, 64'd0,        64'd0,                1'b1},  // 18
    {OP_R, 64'd0,        ex(M,8,7,1,1),        1'b0},  // 19 R11 R4 running
    {OP_W, 64'd0,        64'd0,                1'b0},  // 20 R12 mode-clear write
    {OP_R, 64'd0,        ex(M,0,0,1,1),        1'b0},  // 21 R12 only state fields zeroed
    {OP_W, LD|MV|M,      64'd0,                1'b0},  // 22 R6
    {OP_R, 64'd0,        ex(M|LD|MV,9,0,0,0),  1'b0},  // 23 R6
    {OP_W, M,            64'd0,                1'b0},  // 24 R7 ignored write
    {OP_R, 64'd0,        ex(M|LD|MV,9,0,0,0),  1'b0},  // 25 R7
    {OP_W, CL|M,         64'd0,                1'b0},  // 26 R8
    {OP_R, 64'd0,        ex(M,0,9,0,0),        1'b0}   // 27 R8 R3
  };

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [63:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic do_tod();
    @(negedge clk); tod_sent = 1'b1;
    @(negedge clk); tod_sent = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk64("R1 rd_data after reset", rd_data, 64'd0);
    chk64("R1 tod_ready after reset", 64'(tod_ready), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [63:0] wv, ev;
      logic        er;
      {op, wv, ev, er} = VEC[i];
      case (op)
        OP_W: do_write(wv);
        OP_T: do_tod();
        default: do_read();
      endcase
      if (op == OP_R) chk64($sformatf("R2 table row %0d rd_data", i), rd_data, ev);
      chk64($sformatf("R10 table row %0d tod_ready", i), 64'(tod_ready), 64'(er));
    end

    // R10: move-TOD written outside not-set goes to error
    do_reset();
    do_write(CL|M);
    do_write(MV|M);
    chk64("R10 ready low after bad move", 64'(tod_ready), 64'd0);
    do_read();
    chk64("R10 bad move enters error", rd_data, ex(M|MV,9,0,0,0));

    // R9: load-modulo while in get-TOD ends in error
    do_reset();
    do_write(CL|M);
    do_write(LD|M);
    for (int k = 0; k < 4; k++) do_read();
    do_write(MV|M);
    for (int k = 0; k < 4; k++) do_read();
    chk64("R11 reached get-TOD", rd_data, ex(M|MV,7,6,0,1));
    do_write(LD|M);
    for (int k = 0; k < 3; k++) do_read();
    chk64("R9 still waiting after three polls", rd_data, ex(M|LD,7,6,0,1));
    do_read();
    chk64("R9 load from get-TOD gives error", rd_data, ex(M,9,7,0,1));

    // R1: reset in the middle of a run
    do_reset();
    chk64("R1 rd_data after mid-run reset", rd_data, 64'd0);
    chk64("R1 tod_ready after mid-run reset", 64'(tod_ready), 64'd0);
    do_read();
    chk64("R1 first read after reset", rd_data, M);

    // R13: simultaneous write and read, write wins, rd_data holds
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = LD|M;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk64("R13 rd_data held on collision", rd_data, M);
    for (int k = 0; k < 3; k++) do_read();
    chk64("R13 collision read took no step", rd_data, ex(M|LD,0,0,0,1));
    do_read();
    chk64("R13 fourth poll completes load", rd_data, ex(M,2,1,0,1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule